// File: doc/BRIEF.md
# Serial-Programmed Gain Control with Fast-Attack Attenuation

This block is the digital control section of a variable-gain amplifier. A three-wire serial slave, driven by an active-low chip select, a serial clock and a bidirectional data line, receives 24-bit frames. The frames write or read a single 8-bit control byte. That byte holds a 6-bit base gain in dB and a 2-bit code that selects an attenuation step.

A real-time fast-attack pin subtracts the selected step from the base gain while it is high. When the pin falls, the base gain returns, with no serial traffic needed. An enable pin controls a sleep output. The block reports the effective gain in dB on a 6-bit output.

All pad inputs are brought into the system clock domain by a synchronizer. The serial clock is oversampled, so it must run well below the system clock: at least four system clocks per serial clock phase. The bidirectional data pin is presented as a separate input, output and output-enable, and the pad cell combines them.

Top module: `vga_gain_ctrl`

## Requirements
- R1: After synchronous reset the control byte is 0x00, `gain_db_o` is 0, `sleep_o` is 1 and `spi_sdio_oe_o` is 0.
- R2: A frame is 24 bits, shifted MSB first and sampled on rising serial-clock edges while chip select is low. Frame bit 23 is the operation (0 = write, 1 = read), bits 22..8 are a 15-bit address, and bits 7..0 are data.
- R3: A write frame to address 0x100 with exactly 24 bits updates the control byte when chip select rises. Data bits 7..2 are the base gain in dB, and `gain_db_o` shows that gain while the fast-attack pin is low.
- R4: A write frame to any other address leaves the control byte unchanged.
- R5: A frame that ends with fewer or more than 24 bits leaves the control byte unchanged.
- R6: In a read frame, `spi_sdio_oe_o` rises after the 16th bit. During bits 17..24 the block drives the control byte, MSB first. A read of any address other than 0x100 returns 0x00.
- R7: `spi_sdio_oe_o` falls when chip select rises and stays low while chip select is high.
- R8: While the fast-attack pin is high, `gain_db_o` equals the base gain minus a step. Data bits 1..0 choose the step: code 0 = 2 dB, 1 = 4 dB, 2 = 8 dB, 3 = 16 dB.
- R9: The attenuated gain saturates at 0 when the step is equal to or larger than the base gain.
- R10: When the fast-attack pin falls, `gain_db_o` returns to the base gain.
- R11: A low enable input drives `sleep_o` high, and a high enable input drives it low. The control byte keeps its value through sleep.

Top module port order follows the list below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_csn_i | input | 1 | Serial chip select, active low |
| spi_sclk_i | input | 1 | Serial clock |
| spi_sdio_i | input | 1 | Data line, input side |
| spi_sdio_o | output | 1 | Data line, output side |
| spi_sdio_oe_o | output | 1 | Data line output enable for the pad |
| fast_atk_i | input | 1 | Fast-attack request, active high |
| enable_i | input | 1 | Operation enable, low requests sleep |
| gain_db_o | output | 6 | Effective gain in dB |
| sleep_o | output | 1 | Low-power sleep request |

## Verification
A corrupted control byte is visible at the ports in two ways. It appears on `gain_db_o` about three system clocks after the next fast-attack transition, and it appears in the bits shifted out by the next read frame. A wrong bit counter or a wrong address decode shows up as a write that lands when it should not, or one that is dropped. The bench catches this by reading the byte back in the frame that follows. A stuck output-enable shows up as drive on the data line outside bits 17..24 of a read, which the bench samples within the same frame.

// File: rtl/gainctl_pkg.sv
package gainctl_pkg;

    localparam int ADDR_W  = 15;
    localparam int DATA_W  = 8;
    localparam int GAIN_W  = 6;
    localparam int STEP_W  = DATA_W - GAIN_W;
    localparam int HDR_W   = 1 + ADDR_W;
    localparam int FRAME_W = HDR_W + DATA_W;
    localparam int CNT_W   = $clog2(FRAME_W + 2);

    localparam logic [ADDR_W-1:0] CTRL_ADDR = 15'h100;

    typedef enum logic {
        OP_WRITE = 1'b0,
        OP_READ  = 1'b1
    } op_e;

    typedef struct packed {
        logic [GAIN_W-1:0] gain;
        logic [STEP_W-1:0] step;
    } ctrl_reg_t;

    // Step in dB for a step code: 2 << code
    function automatic logic [GAIN_W-1:0] step_db(input logic [STEP_W-1:0] code);
        return GAIN_W'(2) << code;
    endfunction

    // Base gain minus step, clamped at zero
    function automatic logic [GAIN_W-1:0] attenuate(input logic [GAIN_W-1:0] gain,
                                                     input logic [STEP_W-1:0] code);
        logic [GAIN_W-1:0] s;
        s = step_db(code);
        return (gain > s) ? gain - s : '0;
    endfunction

endpackage

// File: rtl/gainctl_sync.sv
module gainctl_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gainctl_spi_slave.sv
module gainctl_spi_slave
    import gainctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      csn_s,
    input  logic      sclk_s,
    input  logic      sdi_s,
    input  ctrl_reg_t reg_q,
    output logic      wr_valid,
    output ctrl_reg_t wr_data,
    output logic      sdo,
    output logic      sdo_oe
);
    logic               sclk_q, csn_q;
    logic               sclk_rise, csn_rise;
    logic [FRAME_W-1:0] rx_sr, rx_next;
    logic [CNT_W-1:0]   bit_cnt;
    logic [DATA_W-1:0]  tx_sr;
    logic               oe_q;
    logic               hdr_done;

    assign sclk_rise = sclk_s & ~sclk_q;
    assign csn_rise  = csn_s & ~csn_q;
    assign rx_next   = {rx_sr[FRAME_W-2:0], sdi_s};
    assign hdr_done  = sclk_rise && !csn_s && (bit_cnt == CNT_W'(HDR_W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q  <= 1'b0;
            csn_q   <= 1'b1;
            rx_sr   <= '0;
            bit_cnt <= '0;
            tx_sr   <= '0;
            oe_q    <= 1'b0;
        end else begin
            sclk_q <= sclk_s;
            csn_q  <= csn_s;
            if (csn_s) begin
                bit_cnt <= '0;
                oe_q    <= 1'b0;
            end else if (sclk_rise) begin
                rx_sr <= rx_next;
                if (bit_cnt != '1) bit_cnt <= bit_cnt + 1'b1;
                if (hdr_done) begin
                    oe_q  <= (op_e'(rx_next[HDR_W-1]) == OP_READ);
                    tx_sr <= (rx_next[ADDR_W-1:0] == CTRL_ADDR) ? reg_q : '0;
                end else if (bit_cnt >= CNT_W'(HDR_W) && bit_cnt < CNT_W'(FRAME_W)) begin
                    tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
                end
            end
        end
    end

    assign wr_valid = csn_rise && (bit_cnt == CNT_W'(FRAME_W))
                      && (op_e'(rx_sr[FRAME_W-1]) == OP_WRITE)
                      && (rx_sr[FRAME_W-2 -: ADDR_W] == CTRL_ADDR);
    assign wr_data  = ctrl_reg_t'(rx_sr[DATA_W-1:0]);
    assign sdo_oe   = oe_q;
    assign sdo      = oe_q & tx_sr[DATA_W-1];

    // R7
    oe_off_chk: assert property (@(posedge clk) disable iff (rst)
        csn_s |=> !sdo_oe);

    // R6
    oe_after_hdr_chk: assert property (@(posedge clk) disable iff (rst)
        sdo_oe |-> (bit_cnt >= CNT_W'(HDR_W)));

    // R3
    wr_on_cs_rise_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> $past(!csn_s));
endmodule

// File: rtl/gainctl_gain_eval.sv
module gainctl_gain_eval
    import gainctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  ctrl_reg_t         wr_data,
    input  logic              fa_s,
    input  logic              en_s,
    output ctrl_reg_t         reg_q,
    output logic [GAIN_W-1:0] gain_db,
    output logic              sleep
);
    ctrl_reg_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            gain_db <= '0;
            sleep   <= 1'b1;
        end else begin
            if (wr_valid) ctrl_q <= wr_data;
            gain_db <= fa_s ? attenuate(ctrl_q.gain, ctrl_q.step) : ctrl_q.gain;
            sleep   <= !en_s;
        end
    end

    assign reg_q = ctrl_q;

    // R4
    reg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_valid |=> $stable(ctrl_q));

    // R10
    base_gain_chk: assert property (@(posedge clk) disable iff (rst)
        !fa_s |=> (gain_db == $past(ctrl_q.gain)));

    // R9
    atten_bound_chk: assert property (@(posedge clk) disable iff (rst)
        fa_s |=> (gain_db <= $past(ctrl_q.gain)));

    // R11
    sleep_chk: assert property (@(posedge clk) disable iff (rst)
        !en_s |=> sleep);
endmodule

// File: rtl/vga_gain_ctrl.sv
module vga_gain_ctrl
    import gainctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_csn_i,
    input  logic              spi_sclk_i,
    input  logic              spi_sdio_i,
    output logic              spi_sdio_o,
    output logic              spi_sdio_oe_o,
    input  logic              fast_atk_i,
    input  logic              enable_i,
    output logic [GAIN_W-1:0] gain_db_o,
    output logic              sleep_o
);
    localparam int NPIN = 5;

    logic [NPIN-1:0] pin_s;
    logic            csn_s, sclk_s, sdi_s, fa_s, en_s;
    logic            wr_valid;
    ctrl_reg_t       wr_data, reg_q;

    gainctl_sync #(
        .W       (NPIN),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (5'b10000)
    ) sync_i (
        .clk (clk),
        .rst (rst),
        .d   ({spi_csn_i, spi_sclk_i, spi_sdio_i, fast_atk_i, enable_i}),
        .q   (pin_s)
    );

    assign {csn_s, sclk_s, sdi_s, fa_s, en_s} = pin_s;

    gainctl_spi_slave spi_i (
        .clk      (clk),
        .rst      (rst),
        .csn_s    (csn_s),
        .sclk_s   (sclk_s),
        .sdi_s    (sdi_s),
        .reg_q    (reg_q),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .sdo      (spi_sdio_o),
        .sdo_oe   (spi_sdio_oe_o)
    );

    gainctl_gain_eval gain_i (
        .clk      (clk),
        .rst      (rst),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .fa_s     (fa_s),
        .en_s     (en_s),
        .reg_q    (reg_q),
        .gain_db  (gain_db_o),
        .sleep    (sleep_o)
    );
endmodule

// File: tb/vga_gain_ctrl_tb_top.sv
module vga_gain_ctrl_tb_top;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       spi_csn = 1'b1, spi_sclk = 1'b0, spi_sdi = 1'b0;
    logic       fa = 1'b0, en = 1'b0;
    logic       sdo, sdo_oe, sleep;
    logic [5:0] gain;
    int         checks = 0, failures = 0;
    bit         done = 0;

    always #2 clk = ~clk;

    vga_gain_ctrl dut_i (
        .clk           (clk),
        .rst           (rst),
        .spi_csn_i     (spi_csn),
        .spi_sclk_i    (spi_sclk),
        .spi_sdio_i    (spi_sdi),
        .spi_sdio_o    (sdo),
        .spi_sdio_oe_o (sdo_oe),
        .fast_atk_i    (fa),
        .enable_i      (en),
        .gain_db_o     (gain),
        .sleep_o       (sleep)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Sends the top nbits of word MSB first; collects data bits 17..24
    task automatic spi_xfer(input logic [31:0] word, input int nbits,
                            output logic [7:0] rd, output int oe_hits, output int oe_leak);
        rd = '0; oe_hits = 0; oe_leak = 0;
        spi_csn = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < nbits; i++) begin
            spi_sdi = word[31-i];
            wait_clk(HALF);
            if (i >= 16 && i < 24) begin
                rd = {rd[6:0], sdo};
                if (sdo_oe) oe_hits++;
            end else if (sdo_oe) oe_leak++;
            spi_sclk = 1'b1;
            wait_clk(HALF);
            spi_sclk = 1'b0;
        end
        wait_clk(HALF);
        spi_csn = 1'b1;
        wait_clk(2 * HALF);
        if (sdo_oe) oe_leak++;
    endtask

    task automatic spi_write(input logic [14:0] addr, input logic [7:0] data, input int nbits);
        logic [7:0] rd; int h, l;
        spi_xfer({1'b0, addr, data, 8'h00}, nbits, rd, h, l);
    endtask

    task automatic spi_read(input logic [14:0] addr, output logic [7:0] rd, output int h, output int l);
        spi_xfer({1'b1, addr, 8'h00, 8'h00}, 24, rd, h, l);
    endtask

    task automatic t_reset();
        logic [7:0] rd; int h, l;
        check("R1 gain", int'(gain), 0);
        check("R1 sleep", int'(sleep), 1);
        check("R1 oe", int'(sdo_oe), 0);
        en = 1'b1;
        wait_clk(6);
        spi_read(15'h100, rd, h, l);
        check("R1 reg", int'(rd), 0);
    endtask

    task automatic t_write_read();
        logic [7:0] rd; int h, l;
        spi_write(15'h100, 8'hA3, 24);
        check("R3 gain", int'(gain), 40);
        spi_read(15'h100, rd, h, l);
        check("R6 data", int'(rd), 8'hA3);
        check("R6 oe during data", h, 8);
        check("R7 oe outside data", l, 0);
        spi_read(15'h0FF, rd, h, l);
        check("R6 other addr", int'(rd), 0);
        spi_write(15'h100, 8'h54, 24);
        check("R2 gain 21", int'(gain), 21);
        spi_read(15'h100, rd, h, l);
        check("R2 readback", int'(rd), 8'h54);
    endtask

    task automatic t_ignored();
        logic [7:0] rd; int h, l;
        spi_write(15'h101, 8'hFC, 24);
        check("R4 gain", int'(gain), 21);
        spi_write(15'h000, 8'hFC, 24);
        spi_read(15'h100, rd, h, l);
        check("R4 reg", int'(rd), 8'h54);
        spi_write(15'h100, 8'hFC, 20);
        spi_read(15'h100, rd, h, l);
        check("R5 short", int'(rd), 8'h54);
        spi_write(15'h100, 8'hFC, 25);
        spi_read(15'h100, rd, h, l);
        check("R5 long", int'(rd), 8'h54);
    endtask

    task automatic t_fast_attack();
        for (int s = 0; s < 4; s++) begin
            spi_write(15'h100, {6'd40, 2'(s)}, 24);
            fa = 1'b1;
            wait_clk(5);
            check("R8 step", int'(gain), 40 - (2 << s));
            fa = 1'b0;
            wait_clk(5);
            check("R10 release", int'(gain), 40);
        end
        spi_write(15'h100, {6'd5, 2'd3}, 24);
        fa = 1'b1; wait_clk(5);
        check("R9 below", int'(gain), 0);
        fa = 1'b0; wait_clk(5);
        spi_write(15'h100, {6'd16, 2'd3}, 24);
        fa = 1'b1; wait_clk(5);
        check("R9 equal", int'(gain), 0);
        fa = 1'b0; wait_clk(5);
        spi_write(15'h100, {6'd3, 2'd0}, 24);
        fa = 1'b1; wait_clk(5);
        check("R8 small", int'(gain), 1);
        fa = 1'b0; wait_clk(5);
        check("R10 small", int'(gain), 3);
    endtask

    task automatic t_sleep();
        logic [7:0] rd; int h, l;
        spi_write(15'h100, 8'hB6, 24);
        en = 1'b0; wait_clk(5);
        check("R11 sleep on", int'(sleep), 1);
        check("R11 gain kept", int'(gain), 45);
        en = 1'b1; wait_clk(5);
        check("R11 sleep off", int'(sleep), 0);
        spi_read(15'h100, rd, h, l);
        check("R11 reg kept", int'(rd), 8'hB6);
    endtask

    initial begin
        wait_clk(4);
        rst = 1'b0;
        wait_clk(2);
        t_reset();
        t_write_read();
        t_ignored();
        t_fast_attack();
        t_sleep();
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule